// File: doc/BRIEF.md
# Interrupt Enable, Pending and Cause Unit

This unit decides whether a hart with machine, supervisor and user privilege levels must take an interrupt, and which one. Nine hardware request lines arrive: a timer, a software and an external request for each of the three levels. The unit registers them into a pending register. It gates each pending bit with its own per-source enable bit and with the global enable bit for that source's level. Out of every source that qualifies, it picks one by a fixed priority and presents the take request together with the encoded cause value.

Software reaches the two writable registers through a plain single-cycle access port. These are the status-register global enables and the per-source enable register. The port offers full write, set-bits and clear-bits operations, plus a combinational read of the selected register. The pending register can be read on the same port, but its contents follow the hardware lines only. The access port is control traffic and has no back-pressure: an access with `csr_en_i` high takes effect at that clock edge.

Top module: `irq_trap_unit`

## Requirements
- R1: After reset the status enables, the per-source enables and the pending register all read 0, `take_o` is 0 and `cause_o` is 0.
- R2: The per-source enable register holds only bits 0, 1, 3, 4, 5, 7, 8, 9 and 11 (mask 0xBBB). Other bits of a write are dropped and read as 0. Register select `csr_sel_i` values are 0 status, 1 enable, 2 pending and 3 none (reads 0). Operation `csr_op_i` values are 0 read-only, 1 write, 2 set-bits and 3 clear-bits.
- R3: A set-bits access ORs the masked write data into the selected register, and a clear-bits access clears only the bits that are 1 in the write data. All other bits keep their value.
- R4: The status register holds only the global enables: bit 3 machine, bit 1 supervisor and bit 0 user (mask 0xB). Every other bit reads 0.
- R5: The pending register shows each request line one clock after it is sampled. Software requests sit at bits 0 (user), 1 (supervisor) and 3 (machine). Timer requests sit at bits 4, 5 and 7, and external requests at bits 8, 9 and 11.
- R6: Write, set-bits and clear-bits accesses to the pending register change nothing in it.
- R7: A source qualifies only when its pending bit, its enable bit and the global enable of its level are all 1. Bit position b belongs to the level whose status bit is b mod 4. `take_o` is 1 exactly when some source qualifies.
- R8: While `take_o` is 1, `cause_o` has bit XLEN-1 set and holds the cause code in its low bits. The code equals the source's bit position: 0, 1 and 3 for user, supervisor and machine software; 4, 5 and 7 for the timers; 8, 9 and 11 for the external requests.
- R9: When several sources qualify, the chosen code follows this order, highest first: 11, 3, 7, 9, 1, 5, 8, 0, 4.
- R10: While `take_o` is 0, `cause_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_irq_i | input | 3 | Software requests, index 0 user, 1 supervisor, 2 machine |
| tmr_irq_i | input | 3 | Timer requests, same indexing |
| ext_irq_i | input | 3 | External requests, same indexing |
| csr_en_i | input | 1 | Access strobe, applied at the clock edge |
| csr_sel_i | input | 2 | Register select |
| csr_op_i | input | 2 | Access operation |
| csr_wdata_i | input | XLEN | Write / set / clear data |
| csr_rdata_o | output | XLEN | Selected register, combinational |
| take_o | output | 1 | Interrupt must be taken |
| cause_o | output | XLEN | Cause value of the chosen source |

## Verification
Every result of this unit is due one clock edge after its stimulus. A register access updates the status or enable register at the edge where `csr_en_i` is high. A request line reaches the pending register at the next edge. `take_o`, `cause_o` and `csr_rdata_o` follow those registers with no further delay. The bench therefore drives inputs a little after a rising edge, waits through exactly one edge, and reads the outputs shortly after it. It does not wait extra cycles, so a design that adds or drops a stage fails the check.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_LVL  = 3;
  localparam int SRC_W    = 12;
  localparam int GIE_W    = 4;
  localparam int NUM_SRC  = 9;
  localparam logic [SRC_W-1:0] SRC_MASK = 12'hBBB;
  localparam logic [GIE_W-1:0] GIE_MASK = 4'hB;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_ENABLE  = 2'd1,
    SEL_PENDING = 2'd2,
    SEL_NONE    = 2'd3
  } csr_sel_e;

  // Bit position of level index l (0 user, 1 supervisor, 2 machine) within a group of four.
  function automatic int lvl_pos(input int l);
    return (l == 2) ? 3 : l;
  endfunction

  // Source bit position at priority rank r (0 = highest).
  function automatic int rank_bit(input int r);
    case (r)
      0: return 11;
      1: return 3;
      2: return 7;
      3: return 9;
      4: return 1;
      5: return 5;
      6: return 8;
      7: return 0;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 12,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  import irq_pkg::*;

  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    case (csr_op_e'(op))
      OP_WRITE: nxt = wdata & MASK;
      OP_SET:   nxt = q | (wdata & MASK);
      OP_CLEAR: nxt = q & ~wdata;
      default:  nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= nxt;
  end
endmodule

// File: rtl/irq_pend_sample.sv
module irq_pend_sample
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] sw_irq,
  input  logic [NUM_LVL-1:0] tmr_irq,
  input  logic [NUM_LVL-1:0] ext_irq,
  output logic [SRC_W-1:0]   pend
);
  logic [SRC_W-1:0] pend_d;

  always_comb begin
    pend_d = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      pend_d[0 + lvl_pos(l)] = sw_irq[l];
      pend_d[4 + lvl_pos(l)] = tmr_irq[l];
      pend_d[8 + lvl_pos(l)] = ext_irq[l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_d;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_pkg::*;
(
  input  logic [SRC_W-1:0] qual,
  output logic             hit,
  output logic [3:0]       code
);
  always_comb begin
    hit  = 1'b0;
    code = '0;
    for (int r = NUM_SRC - 1; r >= 0; r--) begin
      if (qual[rank_bit(r)]) begin
        hit  = 1'b1;
        code = 4'(rank_bit(r));
      end
    end
  end
endmodule

// File: rtl/irq_trap_unit.sv
module irq_trap_unit
  import irq_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      sw_irq_i,
  input  logic [2:0]      tmr_irq_i,
  input  logic [2:0]      ext_irq_i,
  input  logic            csr_en_i,
  input  logic [1:0]      csr_sel_i,
  input  logic [1:0]      csr_op_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            take_o,
  output logic [XLEN-1:0] cause_o
);
  logic [GIE_W-1:0] gie_q;
  logic [SRC_W-1:0] ena_q;
  logic [SRC_W-1:0] pend_q;
  logic [SRC_W-1:0] lvl_en;
  logic [SRC_W-1:0] qual;
  logic [3:0]       code;
  logic             hit;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^csr_wdata_i[XLEN-1:SRC_W];

  irq_mask_reg #(.W(GIE_W), .MASK(GIE_MASK)) u_gie (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (csr_en_i && csr_sel_e'(csr_sel_i) == SEL_STATUS),
    .op    (csr_op_i),
    .wdata (csr_wdata_i[GIE_W-1:0]),
    .q     (gie_q)
  );

  irq_mask_reg #(.W(SRC_W), .MASK(SRC_MASK)) u_ena (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (csr_en_i && csr_sel_e'(csr_sel_i) == SEL_ENABLE),
    .op    (csr_op_i),
    .wdata (csr_wdata_i[SRC_W-1:0]),
    .q     (ena_q)
  );

  irq_pend_sample u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_irq  (sw_irq_i),
    .tmr_irq (tmr_irq_i),
    .ext_irq (ext_irq_i),
    .pend    (pend_q)
  );

  for (genvar b = 0; b < SRC_W; b++) begin : g_lvl
    assign lvl_en[b] = gie_q[b % 4];
  end

  assign qual = pend_q & ena_q & lvl_en;

  irq_prio_pick u_pick (
    .qual (qual),
    .hit  (hit),
    .code (code)
  );

  always_comb begin
    cause_o = '0;
    if (hit) begin
      cause_o[XLEN-1] = 1'b1;
      cause_o[3:0]    = code;
    end
  end
  assign take_o = hit;

  always_comb begin
    csr_rdata_o = '0;
    case (csr_sel_e'(csr_sel_i))
      SEL_STATUS:  csr_rdata_o[GIE_W-1:0] = gie_q;
      SEL_ENABLE:  csr_rdata_o[SRC_W-1:0] = ena_q;
      SEL_PENDING: csr_rdata_o[SRC_W-1:0] = pend_q;
      default:     csr_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_trap_unit_chk.sv
module irq_trap_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      sw_irq_i,
  input logic [2:0]      tmr_irq_i,
  input logic [2:0]      ext_irq_i,
  input logic            csr_en_i,
  input logic [1:0]      csr_sel_i,
  input logic [1:0]      csr_op_i,
  input logic [XLEN-1:0] csr_wdata_i,
  input logic [XLEN-1:0] csr_rdata_o,
  input logic            take_o,
  input logic [XLEN-1:0] cause_o
);
  a_r2_enable_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_sel_i == 2'd1) |-> ((csr_rdata_o & ~XLEN'(12'hBBB)) == '0));

  a_r4_status_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_sel_i == 2'd0) |-> ((csr_rdata_o & ~XLEN'(4'hB)) == '0));

  a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en_i && csr_sel_i == 2'd1 && csr_op_i == 2'd3 && csr_sel_i == 2'd1)
    |=> (csr_sel_i != 2'd1 || (csr_rdata_o & $past(csr_wdata_i)) == '0));

  a_r5_machine_timer_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_sel_i == 2'd2) |-> (csr_rdata_o[7] == $past(tmr_irq_i[2])));

  a_r8_cause_msb: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (cause_o[XLEN-1] && cause_o[XLEN-2:4] == '0));

  a_r10_idle_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (cause_o == '0));

  a_r6_unused_inputs_ok: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (cause_o[3:0] != 4'd2 && cause_o[3:0] != 4'd6 && cause_o[3:0] != 4'd10
                && (sw_irq_i == sw_irq_i) && (ext_irq_i == ext_irq_i)));
endmodule

bind irq_trap_unit irq_trap_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/irq_trap_unit_tb.sv
module irq_trap_unit_tb;
  localparam int XLEN = 64;
  localparam int HALF = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2:0]      sw_irq_i = '0, tmr_irq_i = '0, ext_irq_i = '0;
  logic            csr_en_i = 1'b0;
  logic [1:0]      csr_sel_i = 2'd3;
  logic [1:0]      csr_op_i = 2'd0;
  logic [XLEN-1:0] csr_wdata_i = '0;
  logic [XLEN-1:0] csr_rdata_o;
  logic            take_o;
  logic [XLEN-1:0] cause_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #HALF clk = ~clk;

  irq_trap_unit #(.XLEN(XLEN)) u_dut (.*);

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic csr_do(input logic [1:0] sel, input logic [1:0] op, input logic [XLEN-1:0] d);
    csr_en_i = 1'b1; csr_sel_i = sel; csr_op_i = op; csr_wdata_i = d;
    step();
    csr_en_i = 1'b0; csr_op_i = 2'd0; csr_wdata_i = '0;
  endtask

  task automatic csr_rd(input logic [1:0] sel, output logic [XLEN-1:0] v);
    csr_sel_i = sel;
    #1;
    v = csr_rdata_o;
  endtask

  task automatic lines(input logic [2:0] s, input logic [2:0] t, input logic [2:0] e);
    sw_irq_i = s; tmr_irq_i = t; ext_irq_i = e;
    step();
  endtask

  function automatic logic [XLEN-1:0] exp_cause(input int code);
    logic [XLEN-1:0] c = '0;
    c[XLEN-1] = 1'b1;
    c[3:0] = 4'(code);
    return c;
  endfunction

  task automatic t_reset();
    logic [XLEN-1:0] v;
    csr_rd(2'd0, v); check("R1 status", v, '0);
    csr_rd(2'd1, v); check("R1 enable", v, '0);
    csr_rd(2'd2, v); check("R1 pending", v, '0);
    check("R1 take", XLEN'(take_o), '0);
    check("R1 cause", cause_o, '0);
  endtask

  task automatic t_enable_mask();
    logic [XLEN-1:0] v;
    csr_do(2'd1, 2'd1, '1);
    csr_rd(2'd1, v); check("R2 enable write mask", v, 64'hBBB);
    csr_rd(2'd3, v); check("R2 none select", v, '0);
    csr_do(2'd1, 2'd0, '0);
    csr_rd(2'd1, v); check("R2 read-only op", v, 64'hBBB);
  endtask

  task automatic t_set_clear();
    logic [XLEN-1:0] v;
    csr_do(2'd1, 2'd1, '0);
    csr_do(2'd1, 2'd2, 64'h880);
    csr_do(2'd1, 2'd2, 64'h00C);
    csr_rd(2'd1, v); check("R3 set bits", v, 64'h888);
    csr_do(2'd1, 2'd3, 64'h080);
    csr_rd(2'd1, v); check("R3 clear bits", v, 64'h808);
    csr_do(2'd0, 2'd1, '1);
    csr_rd(2'd0, v); check("R4 status mask", v, 64'hB);
    csr_do(2'd0, 2'd3, 64'h2);
    csr_rd(2'd0, v); check("R3 status clear", v, 64'h9);
    csr_do(2'd0, 2'd1, '0);
    csr_do(2'd1, 2'd1, '0);
  endtask

  task automatic t_pending();
    logic [XLEN-1:0] v;
    lines(3'b010, 3'b101, 3'b100);
    csr_rd(2'd2, v); check("R5 pending map", v, 64'h892);
    lines(3'b101, 3'b010, 3'b011);
    csr_rd(2'd2, v); check("R5 pending map 2", v, 64'h329);
    csr_do(2'd2, 2'd1, '0);
    csr_rd(2'd2, v); check("R6 write ignored", v, 64'h329);
    csr_do(2'd2, 2'd3, '1);
    csr_rd(2'd2, v); check("R6 clear ignored", v, 64'h329);
    csr_do(2'd2, 2'd2, 64'hFFF);
    csr_rd(2'd2, v); check("R6 set ignored", v, 64'h329);
    lines(3'b000, 3'b000, 3'b000);
  endtask

  task automatic t_qualify();
    for (int b = 0; b < 12; b++) begin
      if (b % 4 == 2) continue;
      begin
        int kind = b / 4;
        int lp = b % 4;
        int li = (lp == 3) ? 2 : lp;
        logic [2:0] onehot = 3'(1 << li);
        csr_do(2'd1, 2'd1, '0);
        csr_do(2'd0, 2'd1, 64'hB);
        lines(kind == 0 ? onehot : 3'b0, kind == 1 ? onehot : 3'b0, kind == 2 ? onehot : 3'b0);
        check($sformatf("R7 no enable b%0d", b), XLEN'(take_o), '0);
        csr_do(2'd0, 2'd1, XLEN'(4'hB & ~(4'(1 << lp))));
        csr_do(2'd1, 2'd1, XLEN'(1) << b);
        check($sformatf("R7 other levels only b%0d", b), XLEN'(take_o), '0);
        check($sformatf("R10 idle cause b%0d", b), cause_o, '0);
        csr_do(2'd0, 2'd1, XLEN'(1) << lp);
        check($sformatf("R7 take b%0d", b), XLEN'(take_o), 1);
        check($sformatf("R8 cause b%0d", b), cause_o, exp_cause(b));
        lines(3'b0, 3'b0, 3'b0);
        check($sformatf("R7 line dropped b%0d", b), XLEN'(take_o), '0);
      end
    end
  endtask

  task automatic t_priority();
    int order[9] = '{11, 3, 7, 9, 1, 5, 8, 0, 4};
    csr_do(2'd0, 2'd1, 64'hB);
    csr_do(2'd1, 2'd1, 64'hBBB);
    lines(3'b111, 3'b111, 3'b111);
    foreach (order[i]) begin
      check($sformatf("R9 rank %0d", i), cause_o, exp_cause(order[i]));
      csr_do(2'd1, 2'd3, XLEN'(1) << order[i]);
    end
    check("R10 all cleared take", XLEN'(take_o), '0);
    check("R10 all cleared cause", cause_o, '0);
    lines(3'b0, 3'b0, 3'b0);
  endtask

  initial begin
    #(200000 * 2 * HALF);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_enable_mask();
    t_set_clear();
    t_pending();
    t_qualify();
    t_priority();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule